// File: doc/BRIEF.md
# Tiled Surface Address Calculator

This block turns the description of a surface in tiled (block-linear) memory into the values a copy datapath needs to walk it. A 12-bit tile-mode word sets the tile geometry. Its inputs are the surface width and height, the x/y/z coordinates of the first element, the bytes per element and a 40-bit base address. From these it produces:

- the 32-bit low word of the start address;
- a high configuration word that carries the upper address byte and the yz tile-size field;
- the tiled pitch;
- the y-tile register value;
- a flag that marks 64-byte tile rows.

A single `start` pulse latches all inputs. Five products are formed one after another on a shift-and-add multiplier that stops early, so the latency depends on the operands. When the results are written, `done` pulses for one cycle. The outputs then hold their values until the next job completes.

Top module: `tiled_surf_addr`

## Requirements
- R1: After reset, `done` and `busy` are 0, `wide_row` is 0, and `addr_lo`, `addr_hi_cfg`, `pitch` and `ytile` are all 0.
- R2: Tile-row width decode. When `tile_mode[3:0]` is 4'hE, the row shift Tp is 4 and `wide_row` is 0. Any other value gives Tp = 6 and `wide_row` = 1.
- R3: The height shift Th is `tile_mode[7:4]` + 2, and the depth shift Td is `tile_mode[11:8]`. Let B = x·bpp. Then:
  - Txo is B mod 2^Tp and Tx is B >> Tp.
  - Tyo is y mod 2^Th and Ty is y >> Th.
  - Tzo is z mod 2^Td and Tz is z >> Td.
- R4: The tile counts are nTx = ceil(width·bpp / 2^Tp) and nTy = ceil(height / 2^Th). The offset is (Txo + (Tyo << Tp) + (Tzo << (Tp+Th))) + ((Tz·nTy·nTx + Ty·nTx + Tx) << (Tp+Th+Td)). `addr_lo` is `base_lo` plus that offset, modulo 2^32. Shifts of 32 or more give 0.
- R5: The carry out of the `addr_lo` addition is added to `base_hi`, modulo 2^8. The result sits in `addr_hi_cfg[23:16]`.
- R6: `addr_hi_cfg` is ORed with the yz tile-size field (1 << (Th−2)) << Td.
- R7: `pitch` is (nTx − 1) << (Tp+Th+Td), truncated to 32 bits.
- R8: `ytile` is (2^Th << 12) ORed with (2^Th − Tyo). It is never 0 after a job.
- R9: Job handshake:
  - A `start` while idle latches every input, and `busy` is 1 from the next cycle until the results are written.
  - `done` is a single-cycle pulse with `busy` low.
  - A `start` while busy is ignored.
  - All outputs hold between one `done` and the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job; inputs are latched on this cycle |
| tile_mode | input | 12 | Tile geometry word (row, height, depth fields) |
| surf_w | input | XW | Surface width in elements |
| surf_h | input | YW | Surface height in rows |
| org_x | input | XW | Start x coordinate |
| org_y | input | YW | Start y coordinate |
| org_z | input | ZW | Start z (layer) coordinate |
| bpp | input | BW | Bytes per element |
| base_lo | input | 32 | Base address bits 31:0 |
| base_hi | input | HW | Base address upper byte |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| addr_lo | output | 32 | Start address low word |
| addr_hi_cfg | output | 32 | Upper address byte at 23:16 ORed with yz tile size |
| pitch | output | 32 | Tiled pitch |
| ytile | output | 32 | Y-tile register value |
| wide_row | output | 1 | Surface uses 64-byte tile rows |

## Verification
The assertions check the following on every cycle:
- `done` is a lone pulse that never coincides with `busy`;
- outputs are frozen whenever the block is idle with no start;
- the row-width flag agrees with the latched mode;
- the multiplier's completion pulse is a single cycle;
- a completed y-tile value is non-zero.

The arithmetic of the address, pitch, carry and tile-size fields can only be shown by the bench's scenarios, which compare against an independent model. Those scenarios cover both row widths, a z offset with non-zero Td, a base address whose carry wraps the high byte, shift totals beyond 32 bits, and a start issued mid-job.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XB,
    ST_WB,
    ST_TY,
    ST_TZA,
    ST_TZB,
    ST_FIN
  } tsa_state_t;
endpackage

// File: rtl/tile_geom_decode.sv
module tile_geom_decode #(
  parameter int SW = 6
) (
  input  logic [11:0]   mode,
  output logic [SW-1:0] tp,
  output logic [SW-1:0] th,
  output logic [SW-1:0] td,
  output logic [SW-1:0] ts,
  output logic          wide
);
  localparam logic [3:0] NARROW_CODE = 4'hE;

  always_comb begin
    wide = (mode[3:0] != NARROW_CODE);
    tp   = wide ? SW'(6) : SW'(4);
    th   = SW'(mode[7:4]) + SW'(2);
    td   = SW'(mode[11:8]);
    ts   = tp + th + td;
  end
endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] p
);
  logic [W-1:0] acc, mcand, mplier;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc    <= '0;
        mcand  <= a;
        mplier <= b;
        busy   <= 1'b1;
      end else if (busy) begin
        if (mplier == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          if (mplier[0]) acc <= acc + mcand;
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
        end
      end
    end
  end

  assign p = acc;

  a_r4_mul_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r4_mul_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/tiled_surf_addr.sv
module tiled_surf_addr #(
  parameter int XW = 19,
  parameter int YW = 13,
  parameter int ZW = 12,
  parameter int BW = 8,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [11:0]   tile_mode,
  input  logic [XW-1:0] surf_w,
  input  logic [YW-1:0] surf_h,
  input  logic [XW-1:0] org_x,
  input  logic [YW-1:0] org_y,
  input  logic [ZW-1:0] org_z,
  input  logic [BW-1:0] bpp,
  input  logic [31:0]   base_lo,
  input  logic [HW-1:0] base_hi,
  output logic          busy,
  output logic          done,
  output logic [31:0]   addr_lo,
  output logic [31:0]   addr_hi_cfg,
  output logic [31:0]   pitch,
  output logic [31:0]   ytile,
  output logic          wide_row
);
  import tsa_pkg::*;

  localparam int DW = 32;
  localparam int SW = 6;
  localparam int HI_POS = 16;

  tsa_state_t state;
  logic [11:0]   tm_q;
  logic [XW-1:0] w_q, x_q;
  logic [YW-1:0] h_q, y_q;
  logic [ZW-1:0] z_q;
  logic [BW-1:0] bpp_q;
  logic [31:0]   blo_q;
  logic [HW-1:0] bhi_q;

  logic [DW-1:0] xb_q, ntx_q, tyn_q, tzn_q;
  logic          kick;

  logic [SW-1:0] tp, th, td, ts;
  logic          wide;

  tile_geom_decode #(.SW(SW)) u_dec (
    .mode(tm_q), .tp(tp), .th(th), .td(td), .ts(ts), .wide(wide)
  );

  logic [DW-1:0] mul_a, mul_b, mul_p;
  logic          mul_busy, mul_done;

  seq_mul #(.W(DW)) u_mul (
    .clk(clk), .rst(rst), .start(kick), .a(mul_a), .b(mul_b),
    .busy(mul_busy), .done(mul_done), .p(mul_p)
  );

  // tile geometry derived from latched inputs
  logic [DW-1:0] mask_p, mask_h, mask_d, rows_h;
  logic [DW-1:0] txo, tx, tyo, ty, tzo, tz, nty;
  logic [DW-1:0] intra, tidx, toff, yz_fld;
  logic [DW:0]   sum_lo;
  logic [HW-1:0] hi_byte;

  always_comb begin
    rows_h = DW'(1) << th;
    mask_p = (DW'(1) << tp) - DW'(1);
    mask_h = rows_h - DW'(1);
    mask_d = (DW'(1) << td) - DW'(1);
    txo    = xb_q & mask_p;
    tx     = xb_q >> tp;
    tyo    = DW'(y_q) & mask_h;
    ty     = DW'(y_q) >> th;
    tzo    = DW'(z_q) & mask_d;
    tz     = DW'(z_q) >> td;
    nty    = (DW'(h_q) + mask_h) >> th;
    intra  = txo + (tyo << tp) + (tzo << (tp + th));
    tidx   = tzn_q + tyn_q + tx;
    toff   = tidx << ts;
    sum_lo = {1'b0, blo_q} + {1'b0, intra + toff};
    hi_byte = bhi_q + HW'(sum_lo[DW]);
    yz_fld = (DW'(1) << (th - SW'(2))) << td;
  end

  always_comb begin
    unique case (state)
      ST_XB:   begin mul_a = DW'(x_q); mul_b = DW'(bpp_q); end
      ST_WB:   begin mul_a = DW'(w_q); mul_b = DW'(bpp_q); end
      ST_TY:   begin mul_a = ty;       mul_b = ntx_q;      end
      ST_TZA:  begin mul_a = tz;       mul_b = nty;        end
      ST_TZB:  begin mul_a = tzn_q;    mul_b = ntx_q;      end
      default: begin mul_a = '0;       mul_b = '0;         end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      kick  <= 1'b0;
      done  <= 1'b0;
      tm_q <= '0; w_q <= '0; x_q <= '0; h_q <= '0; y_q <= '0;
      z_q <= '0; bpp_q <= '0; blo_q <= '0; bhi_q <= '0;
      xb_q <= '0; ntx_q <= '0; tyn_q <= '0; tzn_q <= '0;
      addr_lo <= '0; addr_hi_cfg <= '0; pitch <= '0; ytile <= '0;
      wide_row <= 1'b0;
    end else begin
      kick <= 1'b0;
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          tm_q <= tile_mode; w_q <= surf_w; h_q <= surf_h;
          x_q <= org_x; y_q <= org_y; z_q <= org_z;
          bpp_q <= bpp; blo_q <= base_lo; bhi_q <= base_hi;
          state <= ST_XB;
          kick  <= 1'b1;
        end
        ST_XB: if (mul_done) begin
          xb_q <= mul_p; state <= ST_WB; kick <= 1'b1;
        end
        ST_WB: if (mul_done) begin
          ntx_q <= (mul_p + mask_p) >> tp; state <= ST_TY; kick <= 1'b1;
        end
        ST_TY: if (mul_done) begin
          tyn_q <= mul_p; state <= ST_TZA; kick <= 1'b1;
        end
        ST_TZA: if (mul_done) begin
          tzn_q <= mul_p; state <= ST_TZB; kick <= 1'b1;
        end
        ST_TZB: if (mul_done) begin
          tzn_q <= mul_p; state <= ST_FIN;
        end
        default: begin
          addr_lo     <= sum_lo[DW-1:0];
          addr_hi_cfg <= (DW'(hi_byte) << HI_POS) | yz_fld;
          pitch       <= (ntx_q - DW'(1)) << ts;
          ytile       <= (rows_h << 12) | (rows_h - tyo);
          wide_row    <= wide;
          done        <= 1'b1;
          state       <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(addr_lo) && $stable(addr_hi_cfg) &&
                           $stable(pitch) && $stable(ytile) && $stable(wide_row)));
  a_r2_wide_flag: assert property (@(posedge clk) disable iff (rst)
    done |-> (wide_row == (tm_q[3:0] != 4'hE)));
  a_r8_ytile_nonzero: assert property (@(posedge clk) disable iff (rst)
    done |-> (ytile != '0));
endmodule

// File: tb/tb_tiled_surf_addr.sv
module tb_tiled_surf_addr;
  typedef struct {
    logic [31:0] lo, hi, pt, yt;
    logic        wd;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [11:0] tile_mode = '0;
  logic [18:0] surf_w = '0, org_x = '0;
  logic [12:0] surf_h = '0, org_y = '0;
  logic [11:0] org_z = '0;
  logic [7:0]  bpp = '0, base_hi = '0;
  logic [31:0] base_lo = '0;
  logic busy, done, wide_row;
  logic [31:0] addr_lo, addr_hi_cfg, pitch, ytile;

  int checks = 0, fails = 0, seen = 0;
  exp_t sb[$];
  exp_t last;

  always #2 clk = ~clk;

  tiled_surf_addr dut (
    .clk(clk), .rst(rst), .start(start), .tile_mode(tile_mode),
    .surf_w(surf_w), .surf_h(surf_h), .org_x(org_x), .org_y(org_y),
    .org_z(org_z), .bpp(bpp), .base_lo(base_lo), .base_hi(base_hi),
    .busy(busy), .done(done), .addr_lo(addr_lo), .addr_hi_cfg(addr_hi_cfg),
    .pitch(pitch), .ytile(ytile), .wide_row(wide_row)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [11:0] tm, input longint unsigned w, h,
                                 x, y, z, b, input logic [31:0] blo,
                                 input logic [7:0] bhi, input string tag);
    exp_t e;
    longint unsigned tp, th, td, rowb, hrows, ntx, nty, xb, off, tot, carry, m32;
    m32   = 64'hFFFF_FFFF;
    tp    = (tm[3:0] == 4'hE) ? 4 : 6;           // R2
    th    = longint'(tm[7:4]) + 2;               // R3
    td    = longint'(tm[11:8]);
    rowb  = 64'd1 << tp;
    hrows = 64'd1 << th;
    ntx   = (w * b + rowb - 1) / rowb;           // R4
    nty   = (h + hrows - 1) / hrows;
    xb    = x * b;
    off   = (xb % rowb) + (y % hrows) * rowb + (z % (64'd1 << td)) * rowb * hrows;
    off   = off + ((((z >> td) * nty * ntx + (y / hrows) * ntx + xb / rowb)
                    << (tp + th + td)) & m32);
    tot   = longint'(blo) + (off & m32);
    carry = tot >> 32;
    e.lo  = tot[31:0];
    e.hi  = 32'((((longint'(bhi) + carry) & 64'hFF) << 16)        // R5
                | ((64'd1 << (th - 2)) << td));                  // R6
    e.pt  = 32'(((ntx - 1) << (tp + th + td)) & m32);            // R7
    e.yt  = 32'((hrows << 12) | (hrows - y % hrows));            // R8
    e.wd  = (tp == 6);
    e.tag = tag;
    return e;
  endfunction

  task automatic launch(input logic [11:0] tm, input int w, h, x, y, z, b,
                        input logic [31:0] blo, input logic [7:0] bhi,
                        input string tag, input bit poke_busy);
    int want;
    want = seen + 1;
    @(negedge clk);
    tile_mode = tm; surf_w = 19'(w); surf_h = 13'(h); org_x = 19'(x);
    org_y = 13'(y); org_z = 12'(z); bpp = 8'(b); base_lo = blo; base_hi = bhi;
    start = 1'b1;
    sb.push_back(model(tm, w, h, x, y, z, b, blo, bhi, tag));
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", 32'(busy), 32'd1);
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      tile_mode = 12'h0E0; org_x = 19'd777; base_lo = 32'h1234_0000;
      start = 1'b1;                                  // R9: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (seen < want) @(negedge clk);
    repeat (4) @(negedge clk);
    // R9: outputs hold after done
    chk("R9 hold addr_lo", addr_lo, last.lo);
    chk("R9 hold ytile", ytile, last.yt);
    chk("R9 idle busy", 32'(busy), 32'd0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && done) begin
      exp_t e;
      seen++;
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected done actual=1 expected=0");
      end else begin
        e = sb.pop_front();
        last = e;
        chk({"R4 addr_lo ", e.tag}, addr_lo, e.lo);
        chk({"R5/R6 addr_hi_cfg ", e.tag}, addr_hi_cfg, e.hi);
        chk({"R7 pitch ", e.tag}, pitch, e.pt);
        chk({"R8 ytile ", e.tag}, ytile, e.yt);
        chk({"R2 wide_row ", e.tag}, 32'(wide_row), 32'(e.wd));
        chk({"R9 done without busy ", e.tag}, 32'(busy), 32'd0);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    checks++; fails++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 addr_lo", addr_lo, 32'd0);
    chk("R1 addr_hi_cfg", addr_hi_cfg, 32'd0);
    chk("R1 pitch", pitch, 32'd0);
    chk("R1 ytile", ytile, 32'd0);
    chk("R1 wide_row", 32'(wide_row), 32'd0);

    // R2 narrow rows, R3 minimal Th
    launch(12'h00E, 64, 32, 5, 3, 0, 4, 32'h0010_0000, 8'h01, "narrow", 1'b0);
    // R2 wide rows, Th = 3
    launch(12'h010, 300, 100, 70, 13, 0, 4, 32'h0200_0000, 8'h00, "wide", 1'b0);
    // R3 depth shift with z offset
    launch(12'h21E, 100, 40, 37, 9, 11, 2, 32'h0000_4000, 8'h3C, "depth", 1'b0);
    // R5 carry wraps the high byte
    launch(12'h020, 500, 64, 33, 20, 0, 8, 32'hFFFF_FF00, 8'hFF, "carry", 1'b0);
    // R7 shift total beyond 32 bits
    launch(12'hFF5, 4000, 8000, 1000, 7, 5, 1, 32'h8000_0000, 8'h10, "bigshift", 1'b0);
    // R9 start while busy must be ignored
    launch(12'h132, 1024, 512, 200, 150, 6, 3, 32'h0ABC_0000, 8'h7E, "poke", 1'b1);
    // zero offsets, single tile
    launch(12'h00E, 1, 1, 0, 0, 0, 1, 32'h0000_0000, 8'h00, "origin", 1'b0);

    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R9 pending results actual=%0d expected=0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule